// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances only on cycles where a one-cycle tick enable is high. That tick is a pulse in the system clock domain at the timer base rate, nominally about 1.19 MHz. A load beat supplies a start value and a 3-bit operating mode. The channel then shapes its single output line according to that mode, using the count and a gate input. It supports six behaviours: a level that rises at terminal count, a gate-triggered one-shot, a periodic rate pulse, a square wave, and a strobe pulse started either by the load or by the gate.

Load data arrives on a valid/ready beat. `load_ready` is held high at all times, so the channel never applies back-pressure and every cycle with `load_valid` high is accepted. A new value or mode, and any gate retrigger, is held pending. It takes effect on the next tick after it is accepted, and the count and output change only on ticks. The current count is always visible on `count_rd`. Command decoding, count latching and host bus access belong to surrounding logic.

Top module: `ict_channel`

## Requirements
- R1: A loaded value of 0 is a count of 65536: the period or delay is 65536 ticks, and `count_rd` reads 0x0000 at the start tick and 0xFFFF one tick later.
- R2: Mode 0 (`load_mode`=0): the output is low from the start tick and goes high at the tick where the count reaches 0 (N ticks after start). It then stays high until the next start.
- R3: A low gate suspends counting in modes 0, 2, 3 and 4: ticks then leave the count and the output unchanged. In modes 1 and 5 the gate level does not stop counting.
- R4: Mode 1: a gate rising edge restarts from the loaded value. The output is high from the start tick until the count reaches 0, then low. A retrigger mid-count restarts the full count.
- R5: Mode 2: the count reloads to N on the tick where it would reach 0, and the output is high for exactly that one tick in every N.
- R6: Mode 3: with d ticks since start, the output is high when (d mod N) < (N+1)/2 and low otherwise, with period N.
- R7: Mode encodings 6 and 7 behave as modes 2 and 3.
- R8: A gate rising edge reloads and restarts the count in modes 1, 2, 3 and 5. In modes 0 and 4 it does not.
- R9: Mode 4: the output is high for exactly one tick, N ticks after start, and stays low afterwards until the next start.
- R10: Mode 5: as mode 4, but each gate rising edge restarts the count, giving a fresh one-tick pulse N ticks later.
- R11: In modes 0, 1, 4 and 5, the count keeps decrementing after reaching 0, so `count_rd` wraps to 0xFFFF.
- R12: An accepted load changes nothing until the next tick. That tick sets the count to the new value. Without a tick the count does not change.
- R13: After reset the channel is in mode 3 with a count of 65536, so `count_rd` is 0x0000 and the output is high.
- R14: `load_ready` is always high, and every beat with `load_valid` high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timer base tick |
| gate | input | 1 | Gate level; rising edge retriggers in modes 1, 2, 3, 5 |
| load_valid | input | 1 | Load beat valid |
| load_ready | output | 1 | Load beat ready, always high |
| load_value | input | 16 | Start value, 0 means 65536 |
| load_mode | input | 3 | Operating mode 0..7 |
| wave_out | output | 1 | Channel output line |
| count_rd | output | 16 | Current count |

## Verification
The bench runs a full 65536-tick period from a zero load. A design that treats zero as a count of 0 or 1 pulses far too early. It also loads odd and even square-wave counts. An off-by-one in the half-period compare would show a high phase that is one tick too long or too short. Strobe pulses are watched for several ticks after they fire, which catches a design whose wrapped counter fires a second pulse. Gate edges are applied in a mode that must ignore them and in modes that must restart. This separates a design that reloads on every edge from one that never retriggers.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ict_mode_e;

  // encodings 6 and 7 fold onto the periodic modes
  function automatic ict_mode_e fold_mode(input logic [2:0] raw);
    if (raw[2] && raw[1]) return ict_mode_e'({1'b0, raw[1:0]});
    return ict_mode_e'(raw);
  endfunction

  function automatic logic gate_holds(input ict_mode_e m);
    return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTROBE);
  endfunction

  function automatic logic gate_retrig(input ict_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
  endfunction

  function automatic logic is_periodic(input ict_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic start_level(input ict_mode_e m);
    return (m == M_ONESHOT) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/ict_arm.sv
module ict_arm
  import ict_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          load_valid,
  output logic          load_ready,
  input  logic [CW-1:0] load_value,
  input  logic [2:0]    load_mode,
  output ict_mode_e     mode_o,
  output logic [CW:0]   nval_o,
  output logic          pend_o
);

  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  logic      gate_q;
  logic      gate_rise;
  logic      load_fire;
  ict_mode_e mode_r;
  logic [CW:0] nval_r;
  logic      pend_r;

  assign load_ready = 1'b1;
  assign load_fire  = load_valid & load_ready;
  assign gate_rise  = gate & ~gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      mode_r <= M_SQUARE;
      nval_r <= FULL;
      pend_r <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load_fire) begin
        mode_r <= fold_mode(load_mode);
        nval_r <= (load_value == '0) ? FULL : {1'b0, load_value};
      end
      if (load_fire || (gate_rise && gate_retrig(mode_r)))
        pend_r <= 1'b1;
      else if (tick_en)
        pend_r <= 1'b0;
    end
  end

  assign mode_o = mode_r;
  assign nval_o = nval_r;
  assign pend_o = pend_r;

  // R7
  alias_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && load_mode == 3'd6) |=> (mode_r == M_RATE));
  // R7
  alias_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && load_mode == 3'd7) |=> (mode_r == M_SQUARE));
  // R1
  zero_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && load_value == '0) |=> (nval_r == FULL));

endmodule

// File: rtl/ict_core.sv
module ict_core
  import ict_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        gate,
  input  ict_mode_e   mode,
  input  logic [CW:0] nval,
  input  logic        pend,
  output logic [CW:0] cnt_o,
  output logic [CW:0] cnt_nxt_o,
  output logic        start_o,
  output logic        step_o,
  output logic        zero_o
);

  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [CW:0] ONE  = {{CW{1'b0}}, 1'b1};

  logic [CW:0] cnt_r;
  logic [CW:0] cnt_nxt;
  logic        run_ok;
  logic        start;
  logic        step;
  logic        zero;

  assign run_ok = gate_holds(mode) ? gate : 1'b1;
  assign start  = tick_en & pend;
  assign step   = tick_en & ~pend & run_ok;
  assign zero   = step & (cnt_r == ONE);

  always_comb begin
    cnt_nxt = cnt_r;
    if (start)
      cnt_nxt = nval;
    else if (zero && is_periodic(mode))
      cnt_nxt = nval;
    else if (step)
      cnt_nxt = cnt_r - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_r <= FULL;
    else        cnt_r <= cnt_nxt;
  end

  assign cnt_o     = cnt_r;
  assign cnt_nxt_o = cnt_nxt;
  assign start_o   = start;
  assign step_o    = step;
  assign zero_o    = zero;

  // R12
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && pend) |=> (cnt_r == $past(nval)));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_r));
  // R3
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !pend && !gate && gate_holds(mode)) |=> $stable(cnt_r));

endmodule

// File: rtl/ict_wave.sv
module ict_wave
  import ict_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ict_mode_e   mode,
  input  logic [CW:0] nval,
  input  logic [CW:0] cnt_nxt,
  input  logic        start,
  input  logic        step,
  input  logic        zero,
  output logic        out_o
);

  logic term_r;
  logic out_r;
  logic lvl;

  always_comb begin
    unique case (mode)
      M_TERM:     lvl = term_r | zero;
      M_ONESHOT:  lvl = ~(term_r | zero);
      M_RATE:     lvl = zero;
      M_SQUARE:   lvl = cnt_nxt > (nval >> 1);
      default:    lvl = zero & ~term_r;
    endcase
    if (start) lvl = start_level(mode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_r <= 1'b0;
      out_r  <= 1'b1;
    end else begin
      if (start)     term_r <= 1'b0;
      else if (zero) term_r <= 1'b1;
      if (start || step) out_r <= lvl;
    end
  end

  assign out_o = out_r;

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_SWSTROBE || mode == M_HWSTROBE) && out_r && (start || step)) |=> !out_r);
  // R2
  term_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == M_TERM) |=> !out_r);
  // R2
  term_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TERM && out_r && !start) |=> out_r);
  // R6
  square_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == M_SQUARE) |=> out_r);

endmodule

// File: rtl/ict_channel.sv
module ict_channel
  import ict_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          load_valid,
  output logic          load_ready,
  input  logic [CW-1:0] load_value,
  input  logic [2:0]    load_mode,
  output logic          wave_out,
  output logic [CW-1:0] count_rd
);

  ict_mode_e   mode;
  logic [CW:0] nval;
  logic        pend;
  logic [CW:0] cnt;
  logic [CW:0] cnt_nxt;
  logic        start;
  logic        step;
  logic        zero;

  ict_arm #(.CW(CW)) u_arm (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_value(load_value), .load_mode(load_mode),
    .mode_o(mode), .nval_o(nval), .pend_o(pend)
  );

  ict_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .mode(mode), .nval(nval), .pend(pend),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt),
    .start_o(start), .step_o(step), .zero_o(zero)
  );

  ict_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst_n(rst_n), .mode(mode), .nval(nval),
    .cnt_nxt(cnt_nxt), .start(start), .step(step), .zero(zero),
    .out_o(wave_out)
  );

  assign count_rd = cnt[CW-1:0];

  // R14
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> load_ready);

endmodule

// File: tb/ict_channel_bench.sv
module ict_channel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [15:0] load_value = '0;
  logic [2:0]  load_mode = '0;
  logic        wave_out;
  logic [15:0] count_rd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ict_channel u_ict_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_value(load_value), .load_mode(load_mode),
    .wave_out(wave_out), .count_rd(count_rd)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic load(input logic [15:0] v, input logic [2:0] m);
    load_valid = 1'b1; load_value = v; load_mode = m;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic gate_edge();
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13 count", count_rd, 16'h0000);
    chk("R13 out", wave_out, 1'b1);
    chk("R14 ready", load_ready, 1'b1);
    tk(2);
    chk("R3 mode3 gate low holds", count_rd, 16'h0000);
    gate_edge();
    tk(1);
    chk("R8 mode3 restart", count_rd, 16'h0000);
    tk(1);
    chk("R1 65536 step", count_rd, 16'hFFFF);
  endtask

  task automatic t_mode0();
    load(16'd5, 3'd0);
    tk(1);
    chk("R2 start count", count_rd, 16'd5);
    chk("R2 start low", wave_out, 1'b0);
    tk(4);
    chk("R2 before term", wave_out, 1'b0);
    tk(1);
    chk("R2 at term", wave_out, 1'b1);
    chk("R2 term count", count_rd, 16'd0);
    tk(2);
    chk("R11 wrap", count_rd, 16'hFFFE);
    chk("R2 stays high", wave_out, 1'b1);
  endtask

  task automatic t_gate_hold();
    load(16'd4, 3'd0);
    tk(1);
    gate = 1'b0; @(negedge clk);
    tk(3);
    chk("R3 held count", count_rd, 16'd4);
    gate = 1'b1; @(negedge clk);
    tk(1);
    chk("R8 no retrig mode0", count_rd, 16'd3);
  endtask

  task automatic t_load_wait();
    load(16'd9, 3'd0);
    repeat (3) @(negedge clk);
    chk("R12 no change before tick", count_rd, 16'd3);
    tk(1);
    chk("R12 applied on tick", count_rd, 16'd9);
  endtask

  task automatic t_mode1();
    load(16'd3, 3'd1);
    tk(1);
    chk("R4 start high", wave_out, 1'b1);
    tk(3);
    chk("R4 low at term", wave_out, 1'b0);
    tk(1);
    chk("R11 wrap mode1", count_rd, 16'hFFFF);
    gate_edge();
    tk(1);
    chk("R4 retrig count", count_rd, 16'd3);
    chk("R4 retrig high", wave_out, 1'b1);
    tk(2);
    gate_edge();
    tk(1);
    chk("R4 mid retrig", count_rd, 16'd3);
    tk(2);
    chk("R4 still high", wave_out, 1'b1);
  endtask

  task automatic t_mode2();
    int highs = 0;
    load(16'd3, 3'd2);
    tk(1);
    chk("R5 start low", wave_out, 1'b0);
    tk(2);
    chk("R5 count 1", count_rd, 16'd1);
    tk(1);
    chk("R5 pulse", wave_out, 1'b1);
    chk("R5 reload", count_rd, 16'd3);
    for (int i = 0; i < 9; i++) begin
      tk(1);
      highs += wave_out;
    end
    chk("R5 pulse rate", highs, 3);
  endtask

  task automatic t_mode3();
    load(16'd5, 3'd3);
    tk(1);
    chk("R6 start high", wave_out, 1'b1);
    for (int i = 1; i <= 10; i++) begin
      tk(1);
      chk("R6 odd pattern", wave_out, ((i % 5) < 3) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_alias();
    load(16'd4, 3'd6);
    tk(1);
    tk(3);
    chk("R7 mode6 before", wave_out, 1'b0);
    tk(1);
    chk("R7 mode6 pulse", wave_out, 1'b1);
    chk("R7 mode6 reload", count_rd, 16'd4);
    load(16'd4, 3'd7);
    tk(1);
    tk(2);
    chk("R7 mode7 low half", wave_out, 1'b0);
    tk(2);
    chk("R7 mode7 high again", wave_out, 1'b1);
  endtask

  task automatic t_retrig_sq();
    load(16'd6, 3'd3);
    tk(1);
    tk(3);
    chk("R6 even low", wave_out, 1'b0);
    chk("R8 pre count", count_rd, 16'd3);
    gate_edge();
    tk(1);
    chk("R8 reload count", count_rd, 16'd6);
    chk("R8 reload high", wave_out, 1'b1);
  endtask

  task automatic t_mode4();
    int highs = 0;
    load(16'd3, 3'd4);
    tk(1);
    chk("R9 start low", wave_out, 1'b0);
    tk(2);
    chk("R9 pre pulse", wave_out, 1'b0);
    tk(1);
    chk("R9 pulse", wave_out, 1'b1);
    for (int i = 0; i < 6; i++) begin
      tk(1);
      highs += wave_out;
    end
    chk("R9 no more pulses", highs, 0);
  endtask

  task automatic t_mode5();
    gate = 1'b0;
    load(16'd2, 3'd5);
    tk(1);
    tk(2);
    chk("R10 pulse", wave_out, 1'b1);
    tk(1);
    chk("R10 pulse end", wave_out, 1'b0);
    gate_edge();
    tk(1);
    chk("R10 retrig count", count_rd, 16'd2);
    chk("R10 retrig low", wave_out, 1'b0);
    tk(2);
    chk("R10 second pulse", wave_out, 1'b1);
  endtask

  task automatic t_full();
    gate = 1'b1;
    load(16'd0, 3'd2);
    tk(1);
    chk("R1 start reads 0", count_rd, 16'h0000);
    tk(1);
    chk("R1 next reads ffff", count_rd, 16'hFFFF);
    tk(65534);
    chk("R1 count 1", count_rd, 16'd1);
    chk("R1 no early pulse", wave_out, 1'b0);
    tk(1);
    chk("R1 pulse at 65536", wave_out, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_gate_hold();
    t_load_wait();
    t_mode1();
    gate = 1'b1; @(negedge clk);
    t_mode2();
    t_mode3();
    t_alias();
    t_retrig_sq();
    t_mode4();
    t_mode5();
    t_full();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule